// File: doc/BRIEF.md
# Mode-Dependent GPIO Direction Port

This block is an 8-bit general-purpose I/O port with two byte-wide registers on a small memory-mapped bus: a direction register, where a 1 makes a pin an output, and a data register holding the output latch. The block drives a per-pin output enable and output value, and it samples the pin inputs through a two-flop synchronizer.

The direction register is write-only and always reads back as all ones. A static operating-mode input is captured while reset is held. In the locked modes (3, 4 and 6) the top direction bit resets to 1 and stays at 1, so that pin is a dedicated output. In every other mode the register resets to 0x00. Hardware standby acts exactly like reset. Software standby freezes both registers: bus writes are dropped, and the output pins keep driving their last values.

Software reads the data register to get a per-pin mix: the output latch for output pins and the synchronized pin level for input pins. Read data is registered and is valid in the cycle after the read strobe.

Top module: `gpio_mode_port`

## Requirements
- R1: A write of byte V to offset 0xD1 (direction) makes pin_oe equal V (bit i = 1 means output) from the clock edge that takes the write, except for a locked bit 7.
- R2: A read of offset 0xD1 returns 0xFF on bus_rdata in the cycle after the read strobe, whatever the direction register holds.
- R3: When mode is any value other than 3, 4 or 6 during reset, the direction register leaves reset as 0x00 and every bit can be written.
- R4: When mode is 3, 4 or 6 during reset, the direction register leaves reset as 0x80, and writes cannot clear bit 7, so pin_oe[7] stays 1.
- R5: Asserting hw_stby reinitialises both registers and recaptures the mode, exactly as rst_n low does.
- R6: While sw_stby is 1, bus writes are ignored, and pin_oe and pin_out keep their values.
- R7: A write of byte V to offset 0xD3 (data) sets the output latch to V whatever the pin directions are, and pin_out equals the latch. The latch resets to 0x00 in every mode.
- R8: A read of offset 0xD3 returns (latch AND pin_oe) OR (synchronized pins AND NOT pin_oe), registered, in the cycle after the strobe.
- R9: A change on pin_in reaches the data-register read path after two clock edges: a read sampled at the second edge after the change returns the old level, and a read sampled at the third edge returns the new level.
- R10: The mode input has no effect outside reset. Changing it afterwards changes neither the lock on bit 7 nor any register.
- R11: Reads of any other offset return 0x00, and writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby, treated as reset |
| sw_stby | input | 1 | Software standby: registers frozen, outputs held |
| mode | input | 3 | Operating mode, captured during reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin input levels (asynchronous) |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |

## Verification
Register writes take effect at the edge that accepts them, so the bench checks pin_oe and pin_out at the falling edge right after the write. Read data is registered, so it is sampled at the falling edge after the clock edge that took the read strobe. Pin levels need two more edges through the synchronizer. After every random change to pin_in, the bench waits two cycles before it reads, and a directed case checks both sides of that boundary. Mode locking is checked by driving the mode input away from its reset value and then writing zeros to the direction register.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int MODE_W = 3;

    // Modes in which the top direction bit is pinned to output.
    function automatic logic mode_locks_top(input logic [MODE_W-1:0] m);
        return (m == 3'd3) || (m == 3'd4) || (m == 3'd6);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_q <= '0;
        else         stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];

    // R9
    sync_delay_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $past(stage_q[0]) == stage_q[1]);
endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg
    import gpio_port_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int LOCK_BIT = WIDTH - 1
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  dir_o,
    output logic              locked_o
);
    typedef struct packed {
        logic             locked;
        logic [WIDTH-1:0] dir;
    } dir_state_t;

    dir_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.dir = wdata;
        end
        if (st_q.locked) begin
            st_d.dir[LOCK_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.locked <= mode_locks_top(mode);
            st_q.dir    <= '0;
            if (mode_locks_top(mode)) st_q.dir[LOCK_BIT] <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_o    = st_q.dir;
    assign locked_o = st_q.locked;

    // R10
    lock_stable_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $stable(st_q.locked));
    // R4
    lock_bit_held_chk: assert property (@(posedge clk) disable iff (!arst_n)
        st_q.locked |=> st_q.dir[LOCK_BIT]);
    // R1
    dir_write_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (wr_en && !st_q.locked) |=> st_q.dir == $past(wdata));
endmodule

// File: rtl/gpio_data_reg.sv
module gpio_data_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] latch_o
);
    typedef struct packed {
        logic [WIDTH-1:0] latch;
    } data_state_t;

    data_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.latch = wdata;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign latch_o = st_q.latch;

    // R7
    latch_write_chk: assert property (@(posedge clk) disable iff (!arst_n)
        wr_en |=> latch_o == $past(wdata));
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback #(
    parameter int                WIDTH   = 8,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] DIR_OFS = 8'hD1,
    parameter logic [ADDR_W-1:0] DAT_OFS = 8'hD3
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  dir_i,
    input  logic [WIDTH-1:0]  latch_i,
    input  logic [WIDTH-1:0]  pins_i,
    output logic [WIDTH-1:0]  rdata_o
);
    typedef struct packed {
        logic [WIDTH-1:0] rdata;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d.rdata = '0;
        if (rd_en) begin
            if (addr == DIR_OFS) begin
                st_d.rdata = '1;
            end else if (addr == DAT_OFS) begin
                st_d.rdata = (latch_i & dir_i) | (pins_i & ~dir_i);
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;

    // R2
    dir_reads_ones_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (rd_en && addr == DIR_OFS) |=> rdata_o == '1);
    // R11
    other_reads_zero_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (rd_en && addr != DIR_OFS && addr != DAT_OFS) |=> rdata_o == '0);
endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port
    import gpio_port_pkg::*;
#(
    parameter int                WIDTH   = 8,
    parameter int                ADDR_W  = 8,
    parameter int                SYNC_N  = 2,
    parameter logic [ADDR_W-1:0] DIR_OFS = 8'hD1,
    parameter logic [ADDR_W-1:0] DAT_OFS = 8'hD3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic [MODE_W-1:0] mode,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_out
);
    logic             arst_n;
    logic             wr_ok;
    logic             dir_wr, dat_wr;
    logic [WIDTH-1:0] dir_q, latch_q, pins_sync;
    logic             locked;

    // Hardware standby is a second reset source.
    assign arst_n = rst_n & ~hw_stby;
    assign wr_ok  = bus_wr & ~sw_stby;
    assign dir_wr = wr_ok && (bus_addr == DIR_OFS);
    assign dat_wr = wr_ok && (bus_addr == DAT_OFS);

    gpio_dir_reg #(.WIDTH(WIDTH)) u_dir (
        .clk(clk), .arst_n(arst_n), .mode(mode), .wr_en(dir_wr),
        .wdata(bus_wdata), .dir_o(dir_q), .locked_o(locked)
    );

    gpio_data_reg #(.WIDTH(WIDTH)) u_dat (
        .clk(clk), .arst_n(arst_n), .wr_en(dat_wr),
        .wdata(bus_wdata), .latch_o(latch_q)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .arst_n(arst_n), .async_i(pin_in), .sync_o(pins_sync)
    );

    gpio_readback #(.WIDTH(WIDTH), .ADDR_W(ADDR_W),
                    .DIR_OFS(DIR_OFS), .DAT_OFS(DAT_OFS)) u_rd (
        .clk(clk), .arst_n(arst_n), .rd_en(bus_rd), .addr(bus_addr),
        .dir_i(dir_q), .latch_i(latch_q), .pins_i(pins_sync),
        .rdata_o(bus_rdata)
    );

    assign pin_oe  = dir_q;
    assign pin_out = latch_q;

    // R6
    sw_stby_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
        sw_stby |=> ($stable(pin_oe) && $stable(pin_out)));
    // R8
    data_read_mix_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (bus_rd && bus_addr == DAT_OFS) |=>
        bus_rdata == (($past(pin_out) & $past(pin_oe)) | ($past(pins_sync) & ~$past(pin_oe))));
    // R4
    locked_top_oe_chk: assert property (@(posedge clk) disable iff (!arst_n)
        locked |-> pin_oe[WIDTH-1]);
endmodule

// File: tb/gpio_mode_port_test.sv
module gpio_mode_port_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_DIR = 8'hD1;
    localparam logic [7:0] A_DAT = 8'hD3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, hw_stby = 1'b0, sw_stby = 1'b0;
    logic [2:0] mode = 3'd1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, pin_in = '0;
    logic [7:0] bus_rdata, pin_oe, pin_out;

    int n_chk = 0, n_fail = 0;
    logic [7:0] m_dir, m_dat, m_pin;
    logic       m_lock;

    gpio_mode_port uut (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .mode(mode), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic locks(input logic [2:0] m);
        return (m == 3'd3) || (m == 3'd4) || (m == 3'd6);
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a == A_DIR) return 8'hFF;
        if (a == A_DAT) return (m_dat & m_dir) | (m_pin & ~m_dir);
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_lock = locks(mode);
        m_dir  = m_lock ? 8'h80 : 8'h00;
        m_dat  = 8'h00;
    endtask

    task automatic do_reset(input logic [2:0] m);
        @(negedge clk);
        rst_n = 1'b0; mode = m;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] v);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
        if (!sw_stby) begin
            if (a == A_DIR) m_dir = m_lock ? (v | 8'h80) : v;
            else if (a == A_DAT) m_dat = v;
        end
    endtask

    task automatic do_read(input logic [7:0] a, input string req);
        logic [7:0] e;
        e = exp_read(a);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, e);
    endtask

    task automatic set_pins(input logic [7:0] v);
        pin_in = v; m_pin = v;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int seed_val;
        seed_val = $urandom(32'd20240611);
        m_pin = 8'h00;

        // R3 reset state, unlocked mode
        do_reset(3'd1);
        check("R3 oe after reset", pin_oe, 8'h00);
        check("R7 latch after reset", pin_out, 8'h00);
        do_write(A_DIR, 8'h00);
        check("R3 bit7 writable", pin_oe, 8'h00);
        do_write(A_DIR, 8'hA5);
        check("R1 dir write", pin_oe, 8'hA5);
        do_read(A_DIR, "R2 dir reads ones");
        do_write(A_DAT, 8'h3C);
        check("R7 latch write", pin_out, 8'h3C);

        // R9 synchronizer boundary, all pins input
        do_write(A_DIR, 8'h00);
        pin_in = 8'h5A;
        @(negedge clk);
        do_read(A_DAT, "R9 old level before sync");
        m_pin = 8'h5A;
        do_read(A_DAT, "R9 new level after sync");
        do_write(A_DIR, 8'h0F);
        do_read(A_DAT, "R8 mixed read");

        // R11 other offsets
        do_write(8'hD2, 8'hFF);
        check("R11 stray write oe", pin_oe, 8'h0F);
        check("R11 stray write out", pin_out, 8'h3C);
        do_read(8'hD2, "R11 stray read");

        // R4 locked mode
        do_reset(3'd4);
        check("R4 oe after reset", pin_oe, 8'h80);
        do_write(A_DIR, 8'h00);
        check("R4 bit7 stays", pin_oe, 8'h80);
        do_read(A_DIR, "R2 dir reads ones locked");

        // R10 mode change outside reset
        mode = 3'd1;
        do_write(A_DIR, 8'h01);
        check("R10 lock kept", pin_oe, 8'h81);
        do_reset(3'd2);
        mode = 3'd6;
        do_write(A_DIR, 8'h00);
        check("R10 no lock gained", pin_oe, 8'h00);

        // R6 software standby
        do_write(A_DIR, 8'hF0);
        do_write(A_DAT, 8'hAA);
        sw_stby = 1'b1;
        do_write(A_DIR, 8'h0F);
        do_write(A_DAT, 8'h55);
        check("R6 oe held", pin_oe, 8'hF0);
        check("R6 out held", pin_out, 8'hAA);
        sw_stby = 1'b0;
        @(negedge clk);
        check("R6 oe after exit", pin_oe, 8'hF0);

        // R5 hardware standby in locked mode
        hw_stby = 1'b1; mode = 3'd3;
        repeat (2) @(negedge clk);
        hw_stby = 1'b0;
        model_reset();
        @(negedge clk);
        check("R5 oe after hw standby", pin_oe, 8'h80);
        check("R5 out after hw standby", pin_out, 8'h00);

        // Random phase
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [7:0] v;
            op = $urandom_range(0, 5);
            v = 8'($urandom);
            case (op)
                0: do_write(A_DIR, v);
                1: do_write(A_DAT, v);
                2: do_read(A_DIR, "R2 random");
                3: do_read(A_DAT, "R8 random");
                4: set_pins(v);
                default: begin
                    if ($urandom_range(0, 9) == 0) begin
                        do_reset(3'($urandom_range(0, 7)));
                    end else begin
                        sw_stby = 1'b1;
                        do_write(($urandom_range(0, 1) == 0) ? A_DIR : A_DAT, v);
                        sw_stby = 1'b0;
                    end
                end
            endcase
            check("R1 oe random", pin_oe, m_dir);
            check("R7 out random", pin_out, m_dat);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule